// File: doc/BRIEF.md
# Paired Output Compare Unit

This block drives two waveform outputs from a free-running timer count that it does not own. Each channel keeps a software-written buffer value and an active compare value. The buffer value is copied into the active register on a timer event that software picks per channel. When the timer count equals the active value of an enabled channel, that channel registers a match. The match flips an output level flip-flop and sets a sticky flag, which can raise an interrupt request.

A coupling mode makes the second output flip on a match of either channel, so the pair can produce a pulse whose edges come from two compare values. Each pin shows either the compare level or a general-purpose value, selected per channel. Software can force a level at any time and can read back the current level. Access is through a small register bus with a combinational read path. The data width equals the timer width, and that width must be at least 7.

Top module: `ocmp_pair`

## Requirements
- R1: In normal mode (coupled bit 0), output level 0 inverts on the clock edge at which an enabled channel-0 match is seen, and output level 1 inverts on a channel-1 match only. A match means the compare-enable bit is set and `tmr_cnt_i` equals the active compare value.
- R2: In coupled mode (ctrl bit 4 = 1), output level 0 still inverts only on a channel-0 match. Output level 1 inverts on a match of either channel, and it inverts exactly once when both channels match in the same cycle.
- R3: The transfer select for channel 0 is ctrl bit 5 and for channel 1 is ctrl bit 6. When the select is 0, the buffer is copied into the active compare register at the edge where `tmr_zero_i` is high. When the select is 1, the copy happens where `tmr_clr_i` is high. The other strobe has no effect, and writing a buffer does not change the active compare value by itself.
- R4: A write to address 0 forces both output levels to write-data bits 1:0 (channel 0 on bit 0). A read of address 0 returns the current levels in bits 1:0.
- R5: When a level write and a match occur in the same cycle, the written level is the one that takes effect.
- R6: The output enable bits are ctrl bits 2 (channel 0) and 3 (channel 1). When an enable is 0, the pin follows the matching `gp_i` bit. When it is 1, the pin shows the output level.
- R7: After reset, address 0 reads 0x60: both transfer selects are 1, and the coupled bit, both enables and both levels are 0. Address 3 reads 0, and both interrupt requests are low.
- R8: A channel whose compare-enable bit is 0 never matches. Its output does not flip and its flag does not set.
- R9: Address 3 holds the match flags in bits 1:0, the interrupt enables in bits 3:2 and the compare enables in bits 5:4. A match sets its flag, and writing 0 to a flag bit clears it, while writing 1 keeps it. A match in the same cycle as a clearing write leaves the flag set. `irq_o[i]` is flag i AND interrupt enable i.
- R10: Address 1 writes and reads the channel-0 buffer, and address 2 writes and reads the channel-1 buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for `addr_i`, combinational |
| tmr_cnt_i | input | CNT_W | Shared timer count |
| tmr_zero_i | input | 1 | Timer reached zero strobe |
| tmr_clr_i | input | 1 | Timer compare-clear strobe |
| gp_i | input | 2 | General-purpose pin values |
| pin_o | output | 2 | Output pins |
| irq_o | output | 2 | Per-channel interrupt requests |

## Verification
The assertions assume the timer count and both strobes are stable across each clock edge and change only between edges. They also assume a bus write is a single-cycle pulse whose data stays valid in that cycle. The bench drives every input shortly after an edge, so each edge sees one settled set of values. It sweeps the count through all 256 values of an 8-bit configuration. When the bench combines a match, a strobe and a write in one cycle, it does so on purpose, to reach the precedence corners.

// File: rtl/ocmp_pair_pkg.sv
package ocmp_pair_pkg;
  localparam int NCH    = 2;
  localparam int CTRL_W = 7;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_BUF0 = 2'd1;
  localparam logic [1:0] ADDR_BUF1 = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  typedef struct packed {
    logic [1:0] xsel;
    logic       coupled;
    logic [1:0] oen;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{xsel: 2'b11, coupled: 1'b0, oen: 2'b00};
endpackage

// File: rtl/ocmp_chan.sv
module ocmp_chan #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         buf_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         xsel_i,
  input  logic         zero_i,
  input  logic         clr_i,
  input  logic         cen_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] buf_o,
  output logic         match_o
);
  logic [W-1:0] buf_q, act_q;
  logic         xfer;

  assign xfer    = xsel_i ? clr_i : zero_i;
  assign match_o = cen_i && (cnt_i == act_q);
  assign buf_o   = buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (buf_wr_i) buf_q <= wdata_i;
      if (xfer)     act_q <= buf_q;
    end
  end

  p_xfer_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer |=> act_q == $past(buf_q));
  p_xfer_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer |=> $stable(act_q));
  p_buf_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr_i |=> buf_q == $past(wdata_i));
endmodule

// File: rtl/ocmp_out.sv
module ocmp_out
  import ocmp_pair_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] match_i,
  input  logic           coupled_i,
  input  logic           lvl_wr_i,
  input  logic [NCH-1:0] lvl_wdata_i,
  input  logic [NCH-1:0] oen_i,
  input  logic [NCH-1:0] gp_i,
  output logic [NCH-1:0] lvl_o,
  output logic [NCH-1:0] pin_o
);
  logic [NCH-1:0] lvl_q, tog;

  // second output follows either match when coupled; a double match flips it once
  assign tog[0] = match_i[0];
  assign tog[1] = coupled_i ? (match_i[0] | match_i[1]) : match_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lvl_q <= '0;
    else if (lvl_wr_i) lvl_q <= lvl_wdata_i;
    else               lvl_q <= lvl_q ^ tog;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_pin
    assign pin_o[i] = oen_i[i] ? lvl_q[i] : gp_i[i];
  end

  assign lvl_o = lvl_q;

  p_tog0_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_wr_i && match_i[0]) |=> lvl_q[0] != $past(lvl_q[0]));
  p_tog1_norm_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_wr_i && !coupled_i && match_i[1]) |=> lvl_q[1] != $past(lvl_q[1]));
  p_tog1_norm_iso_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_wr_i && !coupled_i && !match_i[1]) |=> lvl_q[1] == $past(lvl_q[1]));
  p_tog1_cpl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_wr_i && coupled_i && (match_i[0] || match_i[1])) |=> lvl_q[1] != $past(lvl_q[1]));
  p_sw_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_wr_i |=> lvl_q == $past(lvl_wdata_i));
  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_wr_i && match_i == '0) |=> $stable(lvl_q));
endmodule

// File: rtl/ocmp_regs.sv
module ocmp_regs
  import ocmp_pair_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [1:0]              addr_i,
  input  logic [CTRL_W-1:0]       ctl_wdata_i,
  input  logic [NCH-1:0]          lvl_i,
  input  logic [NCH-1:0]          match_i,
  input  logic [NCH-1:0][DW-1:0]  buf_i,
  output ctrl_t                   ctrl_o,
  output logic                    lvl_wr_o,
  output logic [NCH-1:0]          buf_wr_o,
  output logic [NCH-1:0]          cen_o,
  output logic [NCH-1:0]          irq_o,
  output logic [DW-1:0]           rdata_o
);
  ctrl_t          ctrl_q;
  logic [NCH-1:0] flag_q, ien_q, cen_q;
  logic           ctrl_wr, stat_wr;

  assign ctrl_wr     = wr_en_i && (addr_i == ADDR_CTRL);
  assign stat_wr     = wr_en_i && (addr_i == ADDR_STAT);
  assign lvl_wr_o    = ctrl_wr;
  assign buf_wr_o[0] = wr_en_i && (addr_i == ADDR_BUF0);
  assign buf_wr_o[1] = wr_en_i && (addr_i == ADDR_BUF1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      flag_q <= '0;
      ien_q  <= '0;
      cen_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.oen     <= ctl_wdata_i[3:2];
        ctrl_q.coupled <= ctl_wdata_i[4];
        ctrl_q.xsel    <= ctl_wdata_i[6:5];
      end
      if (stat_wr) begin
        ien_q  <= ctl_wdata_i[3:2];
        cen_q  <= ctl_wdata_i[5:4];
        flag_q <= (flag_q & ctl_wdata_i[1:0]) | match_i;  // set beats clear
      end else begin
        flag_q <= flag_q | match_i;
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign cen_o  = cen_q;
  assign irq_o  = flag_q & ien_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[1:0] = lvl_i;
        rdata_o[3:2] = ctrl_q.oen;
        rdata_o[4]   = ctrl_q.coupled;
        rdata_o[6:5] = ctrl_q.xsel;
      end
      ADDR_BUF0: rdata_o = buf_i[0];
      ADDR_BUF1: rdata_o = buf_i[1];
      default: begin
        rdata_o[1:0] = flag_q;
        rdata_o[3:2] = ien_q;
        rdata_o[5:4] = cen_q;
      end
    endcase
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_flag_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_i[i] |=> flag_q[i]);
    p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !(stat_wr && !ctl_wdata_i[i])) |=> flag_q[i]);
    p_flag_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_q[i] && !match_i[i]) |=> !flag_q[i]);
    p_no_match_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cen_q[i] |-> !match_i[i]);
  end
endmodule

// File: rtl/ocmp_pair.sv
module ocmp_pair
  import ocmp_pair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic [CNT_W-1:0] tmr_cnt_i,
  input  logic             tmr_zero_i,
  input  logic             tmr_clr_i,
  input  logic [1:0]       gp_i,
  output logic [1:0]       pin_o,
  output logic [1:0]       irq_o
);
  ctrl_t                   ctrl;
  logic                    lvl_wr;
  logic [NCH-1:0]          buf_wr, cen, match, lvl;
  logic [NCH-1:0][CNT_W-1:0] buf_val;

  ocmp_regs #(.DW(CNT_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .ctl_wdata_i (wdata_i[CTRL_W-1:0]),
    .lvl_i       (lvl),
    .match_i     (match),
    .buf_i       (buf_val),
    .ctrl_o      (ctrl),
    .lvl_wr_o    (lvl_wr),
    .buf_wr_o    (buf_wr),
    .cen_o       (cen),
    .irq_o       (irq_o),
    .rdata_o     (rdata_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ocmp_chan #(.W(CNT_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .buf_wr_i (buf_wr[i]),
      .wdata_i  (wdata_i),
      .xsel_i   (ctrl.xsel[i]),
      .zero_i   (tmr_zero_i),
      .clr_i    (tmr_clr_i),
      .cen_i    (cen[i]),
      .cnt_i    (tmr_cnt_i),
      .buf_o    (buf_val[i]),
      .match_o  (match[i])
    );
  end

  ocmp_out u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .match_i     (match),
    .coupled_i   (ctrl.coupled),
    .lvl_wr_i    (lvl_wr),
    .lvl_wdata_i (wdata_i[1:0]),
    .oen_i       (ctrl.oen),
    .gp_i        (gp_i),
    .lvl_o       (lvl),
    .pin_o       (pin_o)
  );
endmodule

// File: tb/ocmp_pair_bench.sv
module ocmp_pair_bench;
  localparam int W = 8;
  localparam logic [W-1:0] PARK = 8'd251;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, zero = 0, clr = 0;
  logic [1:0] addr = 0, gp = 2'b10;
  logic [W-1:0] wdata = 0, cnt = PARK;
  logic [W-1:0] rdata;
  logic [1:0] pin, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model, built from the requirements
  logic [1:0] m_lvl = 0, m_oen = 0, m_xs = 2'b11, m_flag = 0, m_ien = 0, m_cen = 0;
  logic       m_cpl = 0;
  logic [W-1:0] m_buf [2] = '{0, 0};
  logic [W-1:0] m_act [2] = '{0, 0};

  always #5 clk = ~clk;

  ocmp_pair #(.CNT_W(W)) u_ocmp_pair (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tmr_cnt_i(cnt), .tmr_zero_i(zero), .tmr_clr_i(clr),
    .gp_i(gp), .pin_o(pin), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_pin();
    for (int i = 0; i < 2; i++) exp_pin[i] = m_oen[i] ? m_lvl[i] : gp[i];
  endfunction

  function automatic logic [W-1:0] exp_ctrl();
    return {1'b0, m_xs, m_cpl, m_oen, m_lvl};
  endfunction

  function automatic logic [W-1:0] exp_stat();
    return {2'b00, m_cen, m_ien, m_flag};
  endfunction

  task automatic tick(input string tag);
    logic [1:0] m, tog, n_lvl, n_flag;
    m[0] = m_cen[0] && (cnt == m_act[0]);
    m[1] = m_cen[1] && (cnt == m_act[1]);
    tog[0] = m[0];
    tog[1] = m_cpl ? (m[0] | m[1]) : m[1];
    n_lvl  = (wr_en && addr == 2'd0) ? wdata[1:0] : (m_lvl ^ tog);
    n_flag = ((wr_en && addr == 2'd3) ? (m_flag & wdata[1:0]) : m_flag) | m;
    for (int i = 0; i < 2; i++)
      if (m_xs[i] ? clr : zero) m_act[i] = m_buf[i];
    if (wr_en && addr == 2'd0) begin
      m_oen = wdata[3:2]; m_cpl = wdata[4]; m_xs = wdata[6:5];
    end
    if (wr_en && addr == 2'd3) begin
      m_ien = wdata[3:2]; m_cen = wdata[5:4];
    end
    if (wr_en && addr == 2'd1) m_buf[0] = wdata;
    if (wr_en && addr == 2'd2) m_buf[1] = wdata;
    m_lvl = n_lvl;
    m_flag = n_flag;
    @(posedge clk); #1;
    chk({tag, " pin"}, W'(pin), W'(exp_pin()));
    chk({tag, " irq"}, W'(irq), W'(m_flag & m_ien));
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d, input string tag);
    wr_en = 1; addr = a; wdata = d;
    tick(tag);
    wr_en = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [W-1:0] exp, input string tag);
    addr = a; #1;
    chk({tag, " read"}, rdata, exp);
  endtask

  task automatic sweep(input string tag);
    for (int v = 0; v < 256; v++) begin
      cnt = W'(v);
      tick(tag);
    end
    cnt = PARK;
  endtask

  task automatic ctrl_wr(input logic [1:0] xs, input logic cpl, input logic [1:0] oen,
                         input string tag);
    wr(2'd0, {1'b0, xs, cpl, oen, m_lvl}, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R7 reset state
    rd_chk(2'd0, 8'h60, "R7");
    rd_chk(2'd3, 8'h00, "R7");
    chk("R7 pin", W'(pin), W'(gp));
    chk("R7 irq", W'(irq), 0);
    // R6 general-purpose path
    for (int g = 0; g < 4; g++) begin
      gp = 2'(g); #1;
      chk("R6 gp pin", W'(pin), W'(g));
    end
    ctrl_wr(2'b00, 1'b0, 2'b11, "R6");
    gp = 2'b11; #1;
    chk("R6 oen pin", W'(pin), W'(m_lvl));
    // R10 buffers, R3 zero transfer, R1 normal sweep
    wr(2'd1, 8'd37, "R10");
    wr(2'd2, 8'd200, "R10");
    rd_chk(2'd1, 8'd37, "R10");
    rd_chk(2'd2, 8'd200, "R10");
    wr(2'd3, 8'h30, "R8");
    sweep("R3 pre-xfer");
    zero = 1; tick("R3"); zero = 0;
    sweep("R1");
    rd_chk(2'd3, exp_stat(), "R9");
    chk("R9 both flags", W'(m_flag), 3);
    wr(2'd3, 8'h37, "R9 ien keep");
    wr(2'd3, 8'h36, "R9 clear0");
    rd_chk(2'd3, 8'h36, "R9");
    // R3 select per channel
    ctrl_wr(2'b01, 1'b0, 2'b11, "R3");
    wr(2'd1, 8'd90, "R3");
    wr(2'd2, 8'd120, "R3");
    zero = 1; tick("R3 zero"); zero = 0;
    sweep("R3 after zero");
    clr = 1; tick("R3 clr"); clr = 0;
    sweep("R3 after clr");
    // R2 coupled, equal then distinct
    ctrl_wr(2'b01, 1'b1, 2'b11, "R2");
    wr(2'd2, 8'd90, "R2");
    zero = 1; tick("R2"); zero = 0;
    sweep("R2 same");
    wr(2'd2, 8'd150, "R2");
    zero = 1; tick("R2"); zero = 0;
    sweep("R2 distinct");
    // R8 channel 0 disabled
    wr(2'd3, 8'h27, "R8");
    sweep("R8");
    rd_chk(2'd3, exp_stat(), "R8");
    // R4 level write and readback
    wr(2'd0, {1'b0, m_xs, m_cpl, m_oen, 2'b10}, "R4");
    rd_chk(2'd0, 8'h3E, "R4");
    cnt = 8'd150; tick("R4 match");
    cnt = PARK;
    rd_chk(2'd0, exp_ctrl(), "R4");
    // R5 write beats match
    cnt = 8'd150;
    wr(2'd0, {1'b0, m_xs, m_cpl, m_oen, 2'b11}, "R5");
    cnt = PARK;
    rd_chk(2'd0, 8'h3F, "R5");
    // R9 set beats clear
    cnt = 8'd150;
    wr(2'd3, 8'h24, "R9");
    cnt = PARK;
    rd_chk(2'd3, 8'h26, "R9 set wins");
    chk("R9 irq", W'(irq), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule